// File: doc/BRIEF.md
# Change-Interrupt GPIO Controller

This block is a general-purpose I/O controller for up to 32 pins, with the number of lines set by a parameter. Software reaches it through a simple 32-bit word bus. Each access carries a byte address, a write strobe, write data and read data, and reads are combinational. Each line has a direction bit. One shared data register holds the output values that are driven. Reading it returns the driven value for an output line and the synchronized pad level for an input line.

Input lines pass through a two-stage synchronizer. A third stage holds the previous synchronized level. When the synchronized level of an input line differs from its previous value, the line has changed. This covers both rising and falling transitions. The change is held in a per-line status bit until software acknowledges it by writing a one to that bit. A per-line enable selects which held changes drive one combined interrupt output.

Top module: `chg_gpio_ctrl`

## Requirements
- R1: After reset the direction, output data, interrupt-enable and change registers are all zero, pad_oe_o and pad_out_o are zero, and irq_o is low.
- R2: The direction register is at byte offset 0x00 and reads back as written. A bit value of 1 makes that line an output, and pad_oe_o is equal to the register contents.
- R3: The data register is at byte offset 0x04. A write sets pad_out_o. A read returns the written value for output lines, and for input lines it returns the pad level sampled through two flops, which is valid two clock edges after the pad changes.
- R4: A rising or a falling transition on the pad of an input line sets that line's bit in the change register (byte offset 0x0C) on the third clock edge after the pad changes. Transitions on the pads of output lines set nothing.
- R5: A write to offset 0x0C clears every change bit that is written with 1. Bits written with 0 keep their value.
- R6: When a change arrives on a line in the same clock cycle as a write that acknowledges that line's change bit, the bit stays set.
- R7: The interrupt-enable register is at byte offset 0x08. irq_o is high exactly when at least one line has both its change bit and its enable bit set.
- R8: Offsets 0x10 and 0x14 and all other unmapped offsets read as zero, and writes to them change no register.
- R9: In every register, the bits at and above N_LINES read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address of the access |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| pad_in_i | input | N_LINES | Asynchronous pad levels |
| pad_out_o | output | N_LINES | Output values to drive |
| pad_oe_o | output | N_LINES | Output enables, one per line |
| irq_o | output | 1 | Combined change interrupt |

## Verification
The hardest case to reach is a change that lands in the same cycle as the write that acknowledges the same line. The pad has to toggle at a known position relative to the synchronizer stages, and the acknowledge write has to be issued exactly on the third edge after that toggle. The bench toggles the pad on a falling clock edge, counts two rising edges, and then presents the acknowledge so that the register samples it together with the detected change. The tests also cover the delay of the change bit itself, transitions on output lines that must be ignored, and register bits above the implemented line count.

// File: rtl/chg_gpio_pkg.sv
package chg_gpio_pkg;
    localparam int BUS_W = 32;

    // Word indices (byte offset / 4) of the register map
    localparam int WIDX_DIR   = 0;
    localparam int WIDX_DATA  = 1;
    localparam int WIDX_IEN   = 2;
    localparam int WIDX_CHG   = 3;
    localparam int WIDX_WMASK = 4;
    localparam int WIDX_ITYPE = 5;
endpackage

// File: rtl/chg_gpio_sync.sv
module chg_gpio_sync #(
    parameter int N = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] pad_i,
    output logic [N-1:0] level_o,
    output logic [N-1:0] prev_o
);
    typedef struct packed {
        logic [N-1:0] meta;
        logic [N-1:0] lvl;
        logic [N-1:0] old;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = pad_i;
        st_d.lvl  = st_q.meta;
        st_d.old  = st_q.lvl;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign level_o = st_q.lvl;
    assign prev_o  = st_q.old;
endmodule

// File: rtl/chg_gpio_latch.sv
module chg_gpio_latch #(
    parameter int N = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] level_i,
    input  logic [N-1:0] prev_i,
    input  logic [N-1:0] watch_i,
    input  logic [N-1:0] ack_i,
    output logic [N-1:0] chg_o
);
    logic [N-1:0] hit;
    logic [N-1:0] chg_d, chg_q;

    for (genvar g = 0; g < N; g++) begin : g_line
        always_comb begin
            hit[g]   = (level_i[g] ^ prev_i[g]) & watch_i[g];
            chg_d[g] = (chg_q[g] & ~ack_i[g]) | hit[g];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chg_q <= '0;
        else         chg_q <= chg_d;
    end

    assign chg_o = chg_q;

    // R4, R6
    property p_hit_sets;
        @(posedge clk_i) disable iff (!rst_ni)
        (hit != '0) |=> ((chg_q & $past(hit)) == $past(hit));
    endproperty
    hit_sets_chk: assert property (p_hit_sets);

    // R5
    property p_ack_clears;
        @(posedge clk_i) disable iff (!rst_ni)
        ((ack_i & ~hit) != '0) |=> ((chg_q & $past(ack_i & ~hit)) == '0);
    endproperty
    ack_clears_chk: assert property (p_ack_clears);

    // R5
    property p_idle_holds;
        @(posedge clk_i) disable iff (!rst_ni)
        (ack_i == '0 && hit == '0) |=> $stable(chg_q);
    endproperty
    idle_holds_chk: assert property (p_idle_holds);
endmodule

// File: rtl/chg_gpio_ctrl.sv
module chg_gpio_ctrl
    import chg_gpio_pkg::*;
#(
    parameter int N_LINES = 24,
    parameter int ADDR_W  = 5
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               we_i,
    input  logic [BUS_W-1:0]   wdata_i,
    output logic [BUS_W-1:0]   rdata_o,
    input  logic [N_LINES-1:0] pad_in_i,
    output logic [N_LINES-1:0] pad_out_o,
    output logic [N_LINES-1:0] pad_oe_o,
    output logic               irq_o
);
    localparam int IDX_W = ADDR_W - 2;

    typedef struct packed {
        logic [N_LINES-1:0] dir;
        logic [N_LINES-1:0] dout;
        logic [N_LINES-1:0] ien;
    } regs_t;

    regs_t r_d, r_q;

    logic [IDX_W-1:0]   widx;
    logic [N_LINES-1:0] lvl, prv, chg, ack, din;
    logic               unused_ok;

    assign widx      = addr_i[ADDR_W-1:2];
    assign unused_ok = ^{addr_i[1:0], wdata_i};

    chg_gpio_sync #(.N(N_LINES)) sync_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pad_i  (pad_in_i),
        .level_o(lvl),
        .prev_o (prv)
    );

    chg_gpio_latch #(.N(N_LINES)) latch_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .level_i(lvl),
        .prev_i (prv),
        .watch_i(~r_q.dir),
        .ack_i  (ack),
        .chg_o  (chg)
    );

    always_comb begin
        r_d = r_q;
        ack = '0;
        if (we_i) begin
            if (widx == IDX_W'(WIDX_DIR))  r_d.dir  = wdata_i[N_LINES-1:0];
            if (widx == IDX_W'(WIDX_DATA)) r_d.dout = wdata_i[N_LINES-1:0];
            if (widx == IDX_W'(WIDX_IEN))  r_d.ien  = wdata_i[N_LINES-1:0];
            if (widx == IDX_W'(WIDX_CHG))  ack      = wdata_i[N_LINES-1:0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign din = (r_q.dir & r_q.dout) | (~r_q.dir & lvl);

    always_comb begin
        rdata_o = '0;
        if (widx == IDX_W'(WIDX_DIR))  rdata_o[N_LINES-1:0] = r_q.dir;
        if (widx == IDX_W'(WIDX_DATA)) rdata_o[N_LINES-1:0] = din;
        if (widx == IDX_W'(WIDX_IEN))  rdata_o[N_LINES-1:0] = r_q.ien;
        if (widx == IDX_W'(WIDX_CHG))  rdata_o[N_LINES-1:0] = chg;
    end

    assign pad_out_o = r_q.dout;
    assign pad_oe_o  = r_q.dir;
    assign irq_o     = |(chg & r_q.ien);

    // R7
    property p_masked_quiet;
        @(posedge clk_i) disable iff (!rst_ni)
        (r_q.ien == '0) |-> !irq_o;
    endproperty
    masked_quiet_chk: assert property (p_masked_quiet);

    // R7
    property p_irq_needs_chg;
        @(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (chg != '0);
    endproperty
    irq_needs_chg_chk: assert property (p_irq_needs_chg);

    // R8
    property p_reserved_write;
        @(posedge clk_i) disable iff (!rst_ni)
        (we_i && (widx == IDX_W'(WIDX_WMASK) || widx == IDX_W'(WIDX_ITYPE))) |=> $stable(r_q);
    endproperty
    reserved_write_chk: assert property (p_reserved_write);
endmodule

// File: tb/chg_gpio_ctrl_tb.sv
module chg_gpio_ctrl_tb_top;
    localparam int N = 24;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          we = 1'b0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [N-1:0]  pad_in = '0;
    logic [N-1:0]  pad_out, pad_oe;
    logic          irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    chg_gpio_ctrl #(.N_LINES(N), .ADDR_W(AW)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we),
        .wdata_i(wdata), .rdata_o(rdata), .pad_in_i(pad_in),
        .pad_out_o(pad_out), .pad_oe_o(pad_oe), .irq_o(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(5'h00, v); chk("R1 dir", v, 0);
        rd(5'h04, v); chk("R1 data", v, 0);
        rd(5'h08, v); chk("R1 ien", v, 0);
        rd(5'h0C, v); chk("R1 chg", v, 0);
        chk("R1 oe", 32'(pad_oe), 0);
        chk("R1 out", 32'(pad_out), 0);
        chk("R1 irq", 32'(irq), 0);
    endtask

    task automatic t_dir_data();
        logic [31:0] v;
        wr(5'h00, 32'h0000_00F0);
        rd(5'h00, v); chk("R2 dir readback", v, 32'hF0);
        chk("R2 oe", 32'(pad_oe), 32'hF0);
        wr(5'h04, 32'hFFFF_FFFF);
        chk("R3 pad_out", 32'(pad_out), 32'h00FF_FFFF);
        rd(5'h04, v); chk("R3 data outputs only", v, 32'hF0);
        @(negedge clk); pad_in = 24'h000003;
        settle();
        rd(5'h04, v); chk("R3 data with inputs", v, 32'hF3);
        wr(5'h0C, 32'hFFFF_FFFF);
        rd(5'h0C, v); chk("R5 clear all", v, 0);
    endtask

    task automatic t_change();
        logic [31:0] v;
        @(negedge clk);
        pad_in = pad_in ^ 24'h000120;   // line 8 input, line 5 output
        addr = 5'h0C;
        @(negedge clk); #1 chk("R4 after 1 edge", rdata, 0);
        @(negedge clk); #1 chk("R4 after 2 edges", rdata, 0);
        @(negedge clk); #1 chk("R4 after 3 edges rise", rdata, 32'h100);
        wr(5'h0C, 32'h100);
        rd(5'h0C, v); chk("R5 ack one", v, 0);
        @(negedge clk); pad_in[8] = 1'b0;
        settle();
        rd(5'h0C, v); chk("R4 fall", v, 32'h100);
    endtask

    task automatic t_ack_irq();
        logic [31:0] v;
        @(negedge clk); pad_in[9] = 1'b1;
        settle();
        rd(5'h0C, v); chk("R4 two lines", v, 32'h300);
        chk("R7 no enable", 32'(irq), 0);
        wr(5'h08, 32'h200);
        chk("R7 enabled line", 32'(irq), 1);
        wr(5'h0C, 32'h100);
        rd(5'h0C, v); chk("R5 ack line 8", v, 32'h200);
        wr(5'h0C, 32'h0);
        rd(5'h0C, v); chk("R5 zero write", v, 32'h200);
        wr(5'h08, 32'h100);
        chk("R7 other line masked", 32'(irq), 0);
        wr(5'h08, 32'h200);
        wr(5'h0C, 32'h200);
        chk("R7 cleared", 32'(irq), 0);
    endtask

    task automatic t_race();
        logic [31:0] v;
        @(negedge clk); pad_in[10] = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        addr = 5'h0C; wdata = 32'h400; we = 1'b1;
        @(negedge clk); we = 1'b0;
        rd(5'h0C, v); chk("R6 edge beats ack", v, 32'h400);
        wr(5'h0C, 32'h400);
        rd(5'h0C, v); chk("R5 later ack", v, 0);
    endtask

    task automatic t_reserved();
        logic [31:0] v;
        wr(5'h10, 32'hFFFF_FFFF);
        wr(5'h14, 32'hFFFF_FFFF);
        wr(5'h18, 32'hFFFF_FFFF);
        rd(5'h10, v); chk("R8 wmask", v, 0);
        rd(5'h14, v); chk("R8 itype", v, 0);
        rd(5'h1C, v); chk("R8 unmapped", v, 0);
        rd(5'h00, v); chk("R8 dir kept", v, 32'hF0);
        rd(5'h08, v); chk("R8 ien kept", v, 32'h200);
        chk("R8 out kept", 32'(pad_out), 32'h00FF_FFFF);
    endtask

    task automatic t_upper();
        logic [31:0] v;
        wr(5'h00, 32'hFFFF_FFFF);
        rd(5'h00, v); chk("R9 dir upper", v, 32'h00FF_FFFF);
        rd(5'h04, v); chk("R9 data upper", v, 32'h00FF_FFFF);
        wr(5'h08, 32'hFFFF_FFFF);
        rd(5'h08, v); chk("R9 ien upper", v, 32'h00FF_FFFF);
        @(negedge clk); pad_in[11] = 1'b1;
        settle();
        rd(5'h0C, v); chk("R4 output line ignored", v, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_dir_data();
        t_change();
        t_ack_irq();
        t_race();
        t_reserved();
        t_upper();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule